// File: doc/BRIEF.md
# Multi-Bank Distributed-Arithmetic FIR Correlator

This block computes a long FIR correlation, for example a template match, without a multiplier. The taps are split into equal groups, and each group is served by a small distributed-arithmetic unit. Each unit holds a table of precomputed coefficient sums that is indexed by one bit-slice of its group of delayed samples. Every unit accumulates its table reads MSB-first with a shift, subtracting on the sign slice. After the last bit, the partial results of all units are added into one output word per accepted input sample.

Two run-time knobs trade power against quality. The unit count sets the effective filter length, because disabled units hold their state and add nothing. The bit count sets how many sample bits, starting at the MSB, are clocked through. All units work in parallel, so the number of cycles depends only on the bit count. Results leave as a valid-qualified word toward a downstream buffer. A sample offered while a computation is still running is dropped and reported.

Top module: `da_fir_bank`

## Requirements
- R1: After reset, out_valid, overrun and out_data are 0 and all 64 delay-line taps hold 0.
- R2: Each accepted sample enters tap 0 and pushes the older samples one tap deeper. Unit u (0..15) reads taps 4u..4u+3, and tap 4u+i drives bit i of the unit's table address. Bit j of that address in step k is bit (7-k) of the tap, and step 0 is the sign step. The output is the sum over the active units and over k=0..B-1 of s_k·T_u[addr]·2^(B-1-k), where s_0=-1 and all other s_k=+1.
- R3: cfg_bits selects B, the number of bits processed, in the range 1..8. A value of 0 or above 8 acts as 8. When the table holds coefficient sums, the output equals the sum of c_t·(x_t arithmetically shifted right by 8-B).
- R4: cfg_units selects N, the number of active units, in the range 0..16. A value above 16 acts as 16. Units N..15 add nothing to the output, whatever their tables hold. N=0 gives 0.
- R5: out_valid is a single-cycle pulse that appears B+1 clock edges after the accepting edge, independent of N.
- R6: A sample is accepted when in_valid is high and no computation is running. When in_valid is high during a computation, that sample is discarded, the delay line is unchanged, and overrun is high for the following cycle only.
- R7: The configuration is captured when a sample is accepted. Changes to cfg_bits and cfg_units during a computation do not affect its result.
- R8: A write with tbl_we high stores tbl_data (12-bit signed) into entry tbl_addr of unit tbl_unit. Later results use the new entry.
- R9: The delay line holds the 64 most recent accepted samples. The oldest sample falls off when a new one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 8 | Signed input sample |
| cfg_units | input | 5 | Number of active units |
| cfg_bits | input | 4 | Number of sample bits processed |
| tbl_we | input | 1 | Table write strobe |
| tbl_unit | input | 4 | Unit selected for a table write |
| tbl_addr | input | 4 | Table entry selected for a write |
| tbl_data | input | 12 | Signed table entry value |
| out_valid | output | 1 | One-cycle result qualifier |
| out_data | output | 24 | Signed filter result |
| overrun | output | 1 | Pulse: a sample arrived while busy and was discarded |

## Verification
The bench first streams more than 64 signed samples at full precision with all units enabled. This filling run separates delay-line shifting, tap grouping and overflow of the oldest sample. It then sweeps every bit count against unit counts of 0, 1, 7 and 16. Because the expected value uses a truncated sample, this sweep separates sign-step handling from ordinary steps, and masking of disabled units from table contents. Out-of-range configuration codes, an intruding sample during a run, a configuration change mid-run and a table rewrite each check one rule that the regular stream cannot reach.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
    localparam int SAMPLE_W      = 8;
    localparam int TAPS_PER_UNIT = 4;
    localparam int NUM_UNITS     = 16;
    localparam int TBL_W         = 12;

    localparam int TBL_DEPTH = 1 << TAPS_PER_UNIT;
    localparam int NUM_TAPS  = NUM_UNITS * TAPS_PER_UNIT;
    localparam int UACC_W    = TBL_W + SAMPLE_W;
    localparam int OUT_W     = UACC_W + $clog2(NUM_UNITS);
    localparam int BITS_W    = $clog2(SAMPLE_W + 1);
    localparam int BIDX_W    = $clog2(SAMPLE_W);
    localparam int UNITS_W   = $clog2(NUM_UNITS + 1);
    localparam int UIDX_W    = $clog2(NUM_UNITS);
    localparam int TADDR_W   = TAPS_PER_UNIT;

    typedef logic signed [TBL_W-1:0]  tbl_t;
    typedef logic signed [UACC_W-1:0] uacc_t;
    typedef logic signed [OUT_W-1:0]  out_t;
    typedef logic [TAPS_PER_UNIT-1:0][SAMPLE_W-1:0] grp_t;

    typedef enum logic {PH_IDLE, PH_RUN} phase_e;

    typedef struct packed {
        logic [BITS_W-1:0]  bits;
        logic [UNITS_W-1:0] units;
    } cfg_t;

    function automatic logic [BITS_W-1:0] fix_bits(input logic [BITS_W-1:0] b);
        return (b == '0 || b > BITS_W'(SAMPLE_W)) ? BITS_W'(SAMPLE_W) : b;
    endfunction

    function automatic logic [UNITS_W-1:0] fix_units(input logic [UNITS_W-1:0] n);
        return (n > UNITS_W'(NUM_UNITS)) ? UNITS_W'(NUM_UNITS) : n;
    endfunction
endpackage

// File: rtl/da_tap_line.sv
module da_tap_line
    import da_fir_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               shift,
    input  logic [SAMPLE_W-1:0]                din,
    output logic [NUM_TAPS-1:0][SAMPLE_W-1:0]  taps
);
    logic [NUM_TAPS-1:0][SAMPLE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst)        line_q <= '0;
        else if (shift) line_q <= {line_q[NUM_TAPS-2:0], din};
    end

    assign taps = line_q;

    // R9: the line only moves when a sample is accepted
    p_line_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(line_q));
endmodule

// File: rtl/da_unit.sv
module da_unit
    import da_fir_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               clear,
    input  logic               step,
    input  logic               first,
    input  logic [BIDX_W-1:0]  bit_idx,
    input  grp_t               grp,
    input  logic               wr_en,
    input  logic [TADDR_W-1:0] wr_addr,
    input  tbl_t               wr_data,
    output uacc_t              acc_o
);
    tbl_t               tbl [TBL_DEPTH];
    logic [TADDR_W-1:0] rd_addr;
    tbl_t               rd;
    uacc_t              ext;
    uacc_t              acc_q;

    always_comb begin
        for (int i = 0; i < TAPS_PER_UNIT; i++)
            rd_addr[i] = grp[i][bit_idx];
    end

    assign rd  = tbl[rd_addr];
    assign ext = {{(UACC_W-TBL_W){rd[TBL_W-1]}}, rd};

    always_ff @(posedge clk) begin
        if (wr_en) tbl[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (en) begin
            if (clear)
                acc_q <= '0;
            else if (step)
                acc_q <= first ? (acc_q <<< 1) - ext : (acc_q <<< 1) + ext;
        end
    end

    assign acc_o = acc_q;

    // R4: a disabled unit keeps its state frozen
    p_gated_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));
endmodule

// File: rtl/da_sum_tree.sv
module da_sum_tree
    import da_fir_pkg::*;
(
    input  logic [NUM_UNITS-1:0]             mask,
    input  logic [NUM_UNITS-1:0][UACC_W-1:0] parts,
    output out_t                             total
);
    always_comb begin
        total = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (mask[u])
                total = total + {{(OUT_W-UACC_W){parts[u][UACC_W-1]}}, parts[u]};
        end
    end
endmodule

// File: rtl/da_fir_bank.sv
module da_fir_bank
    import da_fir_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_sample,
    input  logic [4:0]         cfg_units,
    input  logic [3:0]         cfg_bits,
    input  logic               tbl_we,
    input  logic [3:0]         tbl_unit,
    input  logic [3:0]         tbl_addr,
    input  logic [11:0]        tbl_data,
    output logic               out_valid,
    output logic [23:0]        out_data,
    output logic               overrun
);
    phase_e              phase_q;
    logic                busy;
    logic                accept;
    logic [BITS_W-1:0]   cnt_q;
    cfg_t                cfg_q;
    cfg_t                cfg_in;
    logic [UNITS_W-1:0]  units_now;
    logic                sum_go_q;
    logic [BIDX_W-1:0]   bit_idx;
    logic                first;
    logic [NUM_UNITS-1:0] en_now;
    logic [NUM_UNITS-1:0] sum_mask;
    logic [NUM_UNITS-1:0][UACC_W-1:0] parts;
    logic [NUM_TAPS-1:0][SAMPLE_W-1:0] taps;
    out_t                total;
    out_t                out_q;

    assign busy       = (phase_q == PH_RUN);
    assign accept     = in_valid && !busy;
    assign cfg_in     = '{bits: fix_bits(cfg_bits), units: fix_units(cfg_units)};
    assign units_now  = accept ? cfg_in.units : cfg_q.units;
    assign first      = busy && (cnt_q == '0);
    assign bit_idx    = BIDX_W'(SAMPLE_W - 1) - BIDX_W'(cnt_q);

    da_tap_line u_line (
        .clk   (clk),
        .rst   (rst),
        .shift (accept),
        .din   (in_sample),
        .taps  (taps)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        uacc_t acc_u;
        assign en_now[u]   = UNITS_W'(u) < units_now;
        assign sum_mask[u] = UNITS_W'(u) < cfg_q.units;
        assign parts[u]    = acc_u;

        da_unit u_unit (
            .clk     (clk),
            .rst     (rst),
            .en      (en_now[u]),
            .clear   (accept),
            .step    (busy),
            .first   (first),
            .bit_idx (bit_idx),
            .grp     (taps[u*TAPS_PER_UNIT +: TAPS_PER_UNIT]),
            .wr_en   (tbl_we && (tbl_unit == UIDX_W'(u))),
            .wr_addr (tbl_addr),
            .wr_data (tbl_data),
            .acc_o   (acc_u)
        );
    end

    da_sum_tree u_sum (
        .mask  (sum_mask),
        .parts (parts),
        .total (total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            cfg_q     <= '0;
            sum_go_q  <= 1'b0;
            out_valid <= 1'b0;
            out_q     <= '0;
            overrun   <= 1'b0;
        end else begin
            overrun   <= in_valid && busy;
            sum_go_q  <= 1'b0;
            out_valid <= sum_go_q;
            if (sum_go_q) out_q <= total;
            if (accept) begin
                phase_q <= PH_RUN;
                cnt_q   <= '0;
                cfg_q   <= cfg_in;
            end else if (busy) begin
                if (cnt_q == BITS_W'(cfg_q.bits - 1'b1)) begin
                    phase_q  <= PH_IDLE;
                    sum_go_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign out_data = out_q;

    // R5: one pulse per result
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R5: a result only follows a running computation
    p_out_after_run_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(busy, 2));
    // R3: the step counter stays below the captured bit count
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q < cfg_q.bits));
    // R3: the captured bit count is always legal
    p_bits_legal_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cfg_q.bits >= BITS_W'(1) && cfg_q.bits <= BITS_W'(SAMPLE_W)));
    // R7: the captured configuration is frozen during a run
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

// File: tb/sim_da_fir_bank.sv
module sim_da_fir_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_sample;
    logic [4:0]  cfg_units;
    logic [3:0]  cfg_bits;
    logic        tbl_we;
    logic [3:0]  tbl_unit;
    logic [3:0]  tbl_addr;
    logic [11:0] tbl_data;
    logic        out_valid;
    logic [23:0] out_data;
    logic        overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int hist [64];
    int coef [64];

    always #10 clk = ~clk;

    da_fir_bank u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_units(cfg_units), .cfg_bits(cfg_bits), .tbl_we(tbl_we),
        .tbl_unit(tbl_unit), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    function automatic int eff_bits(input int b);
        return (b == 0 || b > 8) ? 8 : b;
    endfunction

    function automatic int eff_units(input int n);
        return (n > 16) ? 16 : n;
    endfunction

    function automatic int model(input int b, input int n);
        int s = 0;
        for (int t = 0; t < n * 4; t++)
            s += coef[t] * (hist[t] >>> (8 - b));
        return s;
    endfunction

    // R8: table entries are coefficient sums selected by address bits
    task automatic load_unit(input int u);
        for (int a = 0; a < 16; a++) begin
            int s = 0;
            for (int i = 0; i < 4; i++)
                if (a[i]) s += coef[u*4 + i];
            @(negedge clk);
            tbl_we = 1'b1; tbl_unit = 4'(u); tbl_addr = 4'(a); tbl_data = 12'(s);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // mode 0: plain, 1: intruding sample during run, 2: config change during run
    task automatic push(input int x, input int mode, input string tag);
        int b, n, expv, cnt, gotv;
        bit got;
        b = eff_bits(int'(cfg_bits));
        n = eff_units(int'(cfg_units));
        @(negedge clk);
        in_valid = 1'b1; in_sample = 8'(x);
        for (int t = 63; t > 0; t--) hist[t] = hist[t-1];
        hist[0] = x;
        expv = model(b, n);
        cnt = 0; got = 0; gotv = 0;
        while (!got && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                in_valid = 1'b0;
                check(overrun == 1'b0, "R6 no overrun on accepted sample", int'(overrun), 0);
                if (mode == 1) begin in_valid = 1'b1; in_sample = 8'(127 - x); end
                if (mode == 2) begin cfg_bits = 4'd2; cfg_units = 5'd1; end
            end
            if (cnt == 2 && mode == 1) begin
                in_valid = 1'b0;
                check(overrun == 1'b1, "R6 overrun on busy sample", int'(overrun), 1);
            end
            if (cnt == 3 && mode == 1)
                check(overrun == 1'b0, "R6 overrun one cycle", int'(overrun), 0);
            if (out_valid) begin got = 1; gotv = int'($signed(out_data)); end
        end
        check(got && cnt == b + 2, {"R5 latency ", tag}, cnt, b + 2);
        check(gotv == expv, {"R2 result ", tag}, gotv, expv);
        @(negedge clk);
        check(out_valid == 1'b0, "R5 single pulse", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sample = '0;
        cfg_units = 5'd16; cfg_bits = 4'd8;
        tbl_we = 1'b0; tbl_unit = '0; tbl_addr = '0; tbl_data = '0;
        for (int t = 0; t < 64; t++) begin
            hist[t] = 0;
            coef[t] = ((t * 37 + 11) % 201) - 100;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        check(overrun == 1'b0, "R1 reset overrun", int'(overrun), 0);
        check(out_data == '0, "R1 reset out_data", int'(out_data), 0);
        for (int u = 0; u < 16; u++) load_unit(u);

        // R1, R9: first outputs see empty taps; then fill past 64 samples
        for (int k = 0; k < 72; k++)
            push(((k * 73 + 29) % 256) - 128, 0, "R9 fill");

        // R3, R4: sweep bit counts against unit counts
        for (int b = 1; b <= 8; b++) begin
            for (int j = 0; j < 4; j++) begin
                int nsel [4] = '{0, 1, 7, 16};
                cfg_bits = 4'(b); cfg_units = 5'(nsel[j]);
                for (int k = 0; k < 2; k++)
                    push(((b * 41 + j * 17 + k * 91) % 256) - 128, 0, "R3 R4 sweep");
            end
        end

        // R3: out-of-range bit codes act as 8
        cfg_units = 5'd16; cfg_bits = 4'd0;  push(-128, 0, "R3 code0");
        cfg_bits = 4'd12;                     push(127, 0, "R3 code12");
        // R4: out-of-range unit code acts as 16
        cfg_bits = 4'd5; cfg_units = 5'd20;   push(-77, 0, "R4 code20");

        // R6: intruding sample is dropped
        cfg_bits = 4'd8; cfg_units = 5'd16;   push(55, 1, "R6 intrude");
        cfg_bits = 4'd1;                      push(-9, 1, "R6 intrude b1");
        cfg_bits = 4'd8;                      push(13, 0, "R6 line unchanged");

        // R7: mid-run configuration change is ignored
        cfg_bits = 4'd6; cfg_units = 5'd12;   push(-100, 2, "R7 cfg change");
        cfg_bits = 4'd6; cfg_units = 5'd12;   push(90, 0, "R7 after");

        // R8: rewrite one unit's table
        for (int i = 0; i < 4; i++) coef[20 + i] = 100 - 30 * i;
        load_unit(5);
        cfg_bits = 4'd8; cfg_units = 5'd16;   push(3, 0, "R8 rewrite");
        push(-3, 0, "R8 rewrite 2");

        done = 1;
        summary();
        $finish;
    end
endmodule